// File: doc/BRIEF.md
# Serial Character Receiver with Per-Entry Error Tags

This block receives asynchronous serial characters and stores them in a 64-entry queue. A divisor-based rate generator produces a sampling strobe at sixteen times the bit rate. A falling edge on the line starts a candidate start bit. That candidate is kept only if the line is still low at the eighth sample. The receiver then collects 5 to 8 data bits, least significant first. It also collects an optional parity bit and the first stop bit.

Every character is written into the queue along with its own parity, framing and break tags. Software can therefore tell exactly which byte was damaged. A long low line is reported as a break, and a single zero entry is stored for it. A character that arrives while the queue is full is discarded, and a sticky overrun status is raised.

For self-test, a loopback select feeds the local transmit output back into the receiver in place of the pin. The head entry of the queue is always visible at the outputs, and a read strobe removes it.

Top module: `uart_rx_core`

## Requirements
- R1: Synchronous active-low reset leaves `fifo_level` at 0 and `overrun` at 0.
- R2: The sampling strobe fires once every `divisor` clocks (a divisor of 0 acts as 1). A bit lasts 16 strobes, and characters are received correctly at divisors 0, 1, 2 and 3.
- R3: A low pulse on the line shorter than 8 samples is rejected and stores no entry.
- R4: `wls` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive LSB first, and unused upper bits of `rd_data` read 0.
- R5: When `par_en`=1, one parity bit follows the data. `par_odd`=0 selects even parity and 1 selects odd. `rd_perr` is 1 when the data ones plus the parity bit do not match the selected sense. When `par_en`=0, no parity bit is expected and `rd_perr` is 0.
- R6: `rd_ferr` is 1 when the first stop-bit sample is low. Only the first stop bit is checked, so a new start bit may immediately follow a single stop bit.
- R7: A break is a line held low through the data, the parity bit and the stop bit. It stores exactly one entry with data 0, `rd_brk`=1, `rd_ferr`=1 and `rd_perr`=0. No further entry is stored until the line has returned high.
- R8: The queue holds 64 entries, and the oldest entry is shown on `rd_data`/`rd_perr`/`rd_ferr`/`rd_brk`. A one-cycle `rd_en` removes that entry. `rd_en` while the queue is empty has no effect on `fifo_level`.
- R9: A character that completes while `fifo_level` is 64 is dropped. The stored entries are unchanged and `overrun` becomes 1. `overrun` stays 1 until a cycle with `rd_en`=1 clears it.
- R10: While `lb_en`=1, the receiver takes its input from `lb_txd` and ignores `rxd`.
- R11: A character stored in the same cycle as a read leaves `fifo_level` unchanged for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive pin, idle high |
| lb_en | input | 1 | 1 selects the loopback source |
| lb_txd | input | 1 | Local transmit output, used in loopback |
| divisor | input | 16 | Clocks per sampling strobe |
| wls | input | 2 | Data length select |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_en | input | 1 | Removes the head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error tag |
| rd_ferr | output | 1 | Head entry framing error tag |
| rd_brk | output | 1 | Head entry break tag |
| fifo_level | output | 7 | Number of stored entries |
| overrun | output | 1 | Sticky overrun status |

## Verification
Two events can land in the same clock: the receiver storing a finished character, and the reader removing the head entry. To provoke this, the queue is first left holding 63 entries. The read strobe is then held high on every clock across the whole stop bit of the next character, so one of those reads must coincide with the store at mid-stop. The result is judged after the stop bit. The level must equal the earlier level, minus the reads, plus one. Draining the queue afterwards must show the surviving entries in order, with the new character last.

// File: rtl/uart_rx_pkg.sv
// Package: shared widths and types of the serial receiver.
// Assumes an 8-bit maximum character and sixteen-fold oversampling.
package uart_rx_pkg;
    localparam int CHAR_W = 8;
    localparam int OSR    = 16;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAITHI
    } rx_state_t;
endpackage

// File: rtl/uart_rx_baud.sv
// Module: sampling strobe generator.
// Emits a one-clock tick every 'divisor' clocks; a divisor of 0 is treated
// as 1. Assumes the divisor is held steady while a character is received.
module uart_rx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    // Purpose: map divisor 0 onto the shortest period.
    always_comb begin
        div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    end

    // Purpose: count clocks and pulse the tick at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div_eff - DIV_W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end

    // R2: with a period above one clock, ticks never come back to back.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_eff > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/uart_rx_framer.sv
// Module: character framer.
// Works on the synchronised line, one step per sampling tick. It validates
// the start bit at the middle sample, then samples the data, parity and the
// first stop bit at mid-bit, and emits one tagged entry per character.
// Assumes line-control inputs do not change while a character is in flight.
module uart_rx_framer
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] wls,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       push,
    output rx_entry_t  entry
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] START_CHK   = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(OSR - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_bit;
    logic              perr_now;
    logic              brk_now;

    // Purpose: index of the final data bit for the selected length.
    always_comb begin
        last_idx = IDX_W'(wls) + IDX_W'(CHAR_W - 4);
    end

    // Purpose: judge parity and break from the bits collected so far.
    always_comb begin
        perr_now = par_en && ((^shreg ^ par_bit) != par_odd);
        brk_now  = (shreg == '0) && (!par_en || !par_bit) && !line;
    end

    // Purpose: frame state machine, stepped once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            push    <= 1'b0;
            entry   <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!line) begin
                            state <= RX_START;
                            cnt   <= CNT_W'(1);
                        end
                    end
                    RX_START: begin
                        if (cnt == START_CHK) begin
                            if (!line) begin
                                state   <= RX_DATA;
                                cnt     <= '0;
                                bit_idx <= '0;
                                shreg   <= '0;
                                par_bit <= 1'b0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_DATA: begin
                        if (cnt == SAMPLE_LAST) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= line;
                            if (bit_idx == last_idx) begin
                                state <= par_en ? RX_PAR : RX_STOP;
                            end else begin
                                bit_idx <= bit_idx + IDX_W'(1);
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_PAR: begin
                        if (cnt == SAMPLE_LAST) begin
                            cnt     <= '0;
                            par_bit <= line;
                            state   <= RX_STOP;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_STOP: begin
                        if (cnt == SAMPLE_LAST) begin
                            cnt  <= '0;
                            push <= 1'b1;
                            if (brk_now) begin
                                entry <= '{brk: 1'b1, ferr: 1'b1, perr: 1'b0, data: '0};
                            end else begin
                                entry <= '{brk: 1'b0, ferr: !line, perr: perr_now, data: shreg};
                            end
                            state <= line ? RX_IDLE : RX_WAITHI;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_WAITHI: begin
                        if (line) begin
                            state <= RX_IDLE;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R7: a character completes in a single clock, never two in a row.
    p_single_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    // R7: while waiting for the line to rise, no character is emitted.
    p_waithi_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_WAITHI && !line) |=> !push);
endmodule

// File: rtl/uart_rx_fifo.sv
// Module: show-ahead queue of tagged entries.
// The head entry is always on dout. A push is accepted only when the queue
// is not full at the start of the cycle; a pop on an empty queue is ignored.
// Assumes DEPTH is a power of two.
module uart_rx_fifo #(
    parameter  int DEPTH = 64,
    parameter  int W     = 11,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level,
    output logic             full
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic             push_ok;
    logic             pop_ok;

    // Purpose: qualify requests against the current fill.
    always_comb begin
        full    = (level == LVL_W'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && (level != '0);
        dout    = mem[rptr];
    end

    // Purpose: store accepted entries.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= din;
        end
    end

    // Purpose: move pointers and track the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= wptr + PTR_W'(1);
            if (pop_ok)  rptr <= rptr + PTR_W'(1);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    // R8: the fill never exceeds the depth.
    p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R8: a read on an empty queue leaves it empty.
    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && pop && !push) |=> level == '0);

    // R9: a push into a full queue without a read keeps it full.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> level == LVL_W'(DEPTH));

    // R11: a push and a pop in one cycle leave the fill unchanged.
    p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && level != '0 && !full) |=> $stable(level));
endmodule

// File: rtl/uart_rx_core.sv
// Module: top of the serial receiver.
// Selects the pin or the loopback source, synchronises it, and drives the
// tick generator, the framer and the tagged queue. Holds the sticky overrun
// status. Assumes rxd and lb_txd are asynchronous to clk and idle high.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int DIV_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              lb_en,
    input  logic              lb_txd,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [1:0]        wls,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              rd_brk,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              overrun
);
    localparam int SYNC_N = 2;

    logic              line_raw;
    logic [SYNC_N-1:0] sync_q;
    logic              tick;
    logic              push;
    rx_entry_t         entry;
    rx_entry_t         head;
    logic              full;

    // Purpose: pick the receive source.
    always_comb begin
        line_raw = lb_en ? lb_txd : rxd;
    end

    // Purpose: bring the line into the clock domain, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_N-2:0], line_raw};
    end

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    uart_rx_framer u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .line    (sync_q[SYNC_N-1]),
        .wls     (wls),
        .par_en  (par_en),
        .par_odd (par_odd),
        .push    (push),
        .entry   (entry)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (entry),
        .pop   (rd_en),
        .dout  (head),
        .level (fifo_level),
        .full  (full)
    );

    // Purpose: unpack the head entry onto the ports.
    always_comb begin
        rd_data = head.data;
        rd_perr = head.perr;
        rd_ferr = head.ferr;
        rd_brk  = head.brk;
    end

    // Purpose: sticky overrun, set by a dropped character, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)             overrun <= 1'b0;
        else if (push && full)  overrun <= 1'b1;
        else if (rd_en)         overrun <= 1'b0;
    end

    // R9: a character arriving at a full queue raises overrun.
    p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_level == LVL_W'(DEPTH)) |=> overrun);

    // R9: a read with no dropped character clears overrun.
    p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(push && fifo_level == LVL_W'(DEPTH))) |=> !overrun);

    // R9: without a read, overrun never falls.
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_en) |=> overrun);
endmodule

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        lb_en = 1'b0;
    logic        lb_txd = 1'b1;
    logic [15:0] divisor = 16'd2;
    logic [1:0]  wls = 2'b11;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_perr, rd_ferr, rd_brk;
    logic [6:0]  fifo_level;
    logic        overrun;

    int checks = 0;
    int fails = 0;
    bit settled = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";
    logic [10:0] model_q[$];
    bit ovr_m = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_core uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .lb_en(lb_en), .lb_txd(lb_txd),
        .divisor(divisor), .wls(wls), .par_en(par_en), .par_odd(par_odd),
        .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .rd_brk(rd_brk), .fifo_level(fifo_level), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Compare the design against the reference queue after every clock.
    always @(posedge clk) begin
        #1;
        if (rst_n && settled && !done) begin
            chk(fifo_level == 7'(model_q.size()), cur_req, "level",
                int'(fifo_level), model_q.size());
            chk(overrun == ovr_m, cur_req, "overrun", int'(overrun), int'(ovr_m));
            if (model_q.size() > 0)
                chk({rd_brk, rd_ferr, rd_perr, rd_data} == model_q[0], cur_req, "head",
                    int'({rd_brk, rd_ferr, rd_perr, rd_data}), int'(model_q[0]));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    task automatic drive(input bit lb, input bit v);
        if (lb) lb_txd = v; else rxd = v;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_push(input logic [10:0] e);
        if (model_q.size() == DEPTH) ovr_m = 1'b1;
        else model_q.push_back(e);
    endfunction

    // Send one character; the expected entry is queued at the end of the stop bit.
    task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v,
                        input bit lb, input int guard);
        int nb;
        int bt;
        logic [7:0] m;
        logic p;
        nb = int'(wls) + 5;
        bt = 16 * ((divisor == 0) ? 1 : int'(divisor));
        m = 8'((16'h1 << nb) - 1);
        p = (^(d & m)) ^ par_odd ^ bad_par;
        settled = 1'b0;
        @(negedge clk);
        drive(lb, 1'b0);
        hold(bt);
        for (int i = 0; i < nb; i++) begin
            drive(lb, d[i]);
            hold(bt);
        end
        if (par_en) begin
            drive(lb, p);
            hold(bt);
        end
        drive(lb, stop_v);
        hold(bt);
        drive(lb, 1'b1);
        model_push({1'b0, !stop_v, par_en && bad_par, d & m});
        settled = 1'b1;
        hold(guard);
    endtask

    task automatic rd_one();
        @(negedge clk);
        rd_en = 1'b1;
        if (model_q.size() > 0) void'(model_q.pop_front());
        ovr_m = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain();
        while (model_q.size() > 0) rd_one();
        hold(2);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(fifo_level == 0, "R1", "level in reset", int'(fifo_level), 0);
        chk(overrun == 1'b0, "R1", "overrun in reset", int'(overrun), 0);
        @(negedge clk);
        rst_n = 1'b1;
        settled = 1'b1;
        hold(40);

        // R4: every data length, 8N1 first
        cur_req = "R4";
        for (int w = 3; w >= 0; w--) begin
            wls = 2'(w);
            send(8'hA5 ^ 8'(w * 17), 1'b0, 1'b1, 1'b0, 40);
        end
        chk(fifo_level == 4, "R4", "four lengths stored", int'(fifo_level), 4);
        drain();

        // R2: divisors 0, 1 and 3
        cur_req = "R2";
        wls = 2'b11;
        divisor = 16'd1;  hold(10); send(8'h3C, 1'b0, 1'b1, 1'b0, 40);
        divisor = 16'd0;  hold(10); send(8'hC3, 1'b0, 1'b1, 1'b0, 40);
        divisor = 16'd3;  hold(10); send(8'h81, 1'b0, 1'b1, 1'b0, 60);
        chk(fifo_level == 3, "R2", "three divisors stored", int'(fifo_level), 3);
        drain();
        divisor = 16'd2;
        hold(10);

        // R5: even and odd parity, good and bad
        cur_req = "R5";
        par_en = 1'b1;
        par_odd = 1'b0; send(8'h17, 1'b0, 1'b1, 1'b0, 40); send(8'h17, 1'b1, 1'b1, 1'b0, 40);
        par_odd = 1'b1; send(8'h6E, 1'b0, 1'b1, 1'b0, 40); send(8'h6E, 1'b1, 1'b1, 1'b0, 40);
        wls = 2'b01;    send(8'h2B, 1'b1, 1'b1, 1'b0, 40);
        chk(rd_perr == 1'b0, "R5", "good even head", int'(rd_perr), 0);
        drain();
        par_en = 1'b0;
        wls = 2'b11;

        // R6: low stop bit, then back-to-back single-stop characters
        cur_req = "R6";
        send(8'h5A, 1'b0, 1'b0, 1'b0, 40);
        chk(rd_ferr == 1'b1, "R6", "framing tag", int'(rd_ferr), 1);
        send(8'h11, 1'b0, 1'b1, 1'b0, 0);
        send(8'h22, 1'b0, 1'b1, 1'b0, 0);
        send(8'h44, 1'b0, 1'b1, 1'b0, 40);
        chk(fifo_level == 4, "R6", "back-to-back count", int'(fifo_level), 4);
        drain();

        // R3: a short low pulse is rejected
        cur_req = "R3";
        settled = 1'b0;
        @(negedge clk); rxd = 1'b0; hold(10); rxd = 1'b1;
        hold(400);
        settled = 1'b1;
        hold(2);
        chk(fifo_level == 0, "R3", "glitch ignored", int'(fifo_level), 0);

        // R7: break stores one zero entry
        cur_req = "R7";
        settled = 1'b0;
        @(negedge clk); rxd = 1'b0; hold(32 * 14); rxd = 1'b1;
        model_push({1'b1, 1'b1, 1'b0, 8'h00});
        hold(64);
        settled = 1'b1;
        hold(2);
        chk(fifo_level == 1 && rd_brk == 1'b1, "R7", "single break entry",
            int'({fifo_level, rd_brk}), int'({7'd1, 1'b1}));
        drain();

        // R10: loopback source while the pin is held low
        cur_req = "R10";
        lb_en = 1'b1;
        rxd = 1'b0;
        hold(10);
        send(8'h96, 1'b0, 1'b1, 1'b1, 40);
        chk(fifo_level == 1 && rd_data == 8'h96, "R10", "loopback char",
            int'(rd_data), 'h96);
        rxd = 1'b1;
        hold(10);
        lb_en = 1'b0;
        hold(10);

        // R8: reading an empty queue
        cur_req = "R8";
        drain();
        rd_one();
        hold(2);
        chk(fifo_level == 0, "R8", "empty read ignored", int'(fifo_level), 0);

        // R9: fill to 64, drop the 65th
        cur_req = "R9";
        divisor = 16'd1;
        hold(10);
        for (int i = 0; i < DEPTH + 1; i++) send(8'(i * 7 + 1), 1'b0, 1'b1, 1'b0, 4);
        hold(10);
        chk(overrun == 1'b1, "R9", "overrun set", int'(overrun), 1);
        chk(fifo_level == 64, "R9", "level full", int'(fifo_level), 64);
        chk(rd_data == 8'h01, "R9", "oldest kept", int'(rd_data), 1);
        rd_one();
        hold(2);
        chk(overrun == 1'b0, "R9", "overrun cleared by read", int'(overrun), 0);

        // R11: reads on every clock of the stop bit
        cur_req = "R11";
        fork
            send(8'hE7, 1'b0, 1'b1, 1'b0, 40);
            begin
                hold(16 * 9 + 1);
                for (int k = 0; k < 16; k++) begin
                    @(negedge clk);
                    rd_en = 1'b1;
                    void'(model_q.pop_front());
                    ovr_m = 1'b0;
                end
                @(negedge clk);
                rd_en = 1'b0;
            end
        join
        hold(4);
        chk(fifo_level == 7'd48, "R11", "level after overlap", int'(fifo_level), 48);
        drain();
        chk(fifo_level == 0, "R11", "drained", int'(fifo_level), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule